// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block is the control sequencer of a processor that keeps its general registers in memory, not in a register file. A workspace pointer (WP) gives the base of the active register set, and register n sits at byte address WP + 2·n. The sequencer keeps the WP, program counter (PC) and status (ST) registers. It carries out four flows over a single word-wide memory port: a call that changes workspace, the matching return, a plain branch-and-link, and interrupt entry.

A call reads a two-word vector: first the new workspace base, then the new code address. It then stores the caller's WP, return PC and ST in registers 13, 14 and 15 of the new workspace, and only after that makes the new WP and PC live. There is no stack pointer, because the saved context lives in the callee's own register set. The return reloads all three registers from slots 13 to 15 of the current workspace. The saved PC is the word after the call instruction, so a callee can step over in-line arguments by advancing its R14 before it returns. Interrupt entry runs the call flow through a vector at a fixed address and saves the current PC.

Commands arrive on a valid/ready channel. The memory request channel is also valid/ready: a request must stay unchanged while it waits for ready. A write is complete when it is accepted. A read returns its data with `rsp_valid` at least one cycle after it is accepted. Only one access is in flight at a time.

Top module: `ctx_switch_seq`

## Requirements
- R1: After reset, wp, pc and st hold the values of the parameters RST_WP, RST_PC and RST_ST, busy is 0 and cmd_ready is 1.
- R2: The byte address of register n of a workspace is that workspace's base plus 2·n. Slots 11, 13, 14 and 15 therefore sit at +22, +26, +28 and +30.
- R3: A call (cmd_op = 0) performs exactly five accesses in this order: read vector, read vector+2, write old wp to slot 13 of the new workspace, write cmd_next_pc to slot 14, write st to slot 15. After that, wp takes the first vector word and pc takes the second. st is unchanged.
- R4: A return (cmd_op = 1) reads slots 13, 14 and 15 of the current workspace, in that order, and loads them into wp, pc and st. pc is restored from the value held in slot 14 at that time, so an advanced R14 skips in-line data.
- R5: A branch-and-link (cmd_op = 2) makes one write of cmd_next_pc to slot 11 of the current workspace and sets pc to cmd_addr. wp and st are unchanged.
- R6: When the sequencer is idle, irq_req is 1 and irq_level ≥ st[3:0], irq_ack pulses for one cycle. The sequencer then runs the call flow through the vector at IRQ_VEC, saving the current pc as the return address.
- R7: An interrupt whose level is below st[3:0] causes no irq_ack, no memory access and no register change.
- R8: An interrupt raised while a flow is running waits until that flow has finished all its accesses. When an interrupt and a command are both pending at an idle cycle, the interrupt goes first and the command is accepted after it.
- R9: Bit 0 of every memory request address is 0, including when the vector address in cmd_addr is odd.
- R10: While req_valid is 1 and req_ready is 0, req_addr, req_we and req_wdata stay stable. The next access is not issued until the current one completes.
- R11: cmd_ready is 1 only when the sequencer is idle and is not taking an interrupt in that cycle. While busy is 1, neither cmd_ready nor irq_ack is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| cmd_op | input | 2 | 0 call, 1 return, 2 branch-and-link, 3 no effect |
| cmd_addr | input | AW | Vector address (call) or branch target (branch-and-link) |
| cmd_next_pc | input | AW | Address of the word after the instruction |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | LW | Level of the requesting interrupt |
| irq_ack | output | 1 | One-cycle pulse when interrupt entry starts |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_we | output | 1 | 1 write, 0 read |
| req_addr | output | AW | Byte address, bit 0 always 0 |
| req_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DW | Read data |
| wp | output | AW | Workspace pointer |
| pc | output | AW | Program counter |
| st | output | DW | Status register, bits 3:0 hold the interrupt mask |
| busy | output | 1 | A flow is in progress |

## Verification
The bench records every memory access. If the order of the saves were wrong, or if WP were switched before the saves, the recorded addresses would not match. A slot offset off by one register would put the saved words in the wrong place. It gives an odd vector address so that a missing alignment shows up as an odd request address. It raises an interrupt at exactly the mask level, where a strict comparison would wrongly refuse it, and one level below, where it must stay silent. While a call is running it raises an interrupt and offers a branch-and-link together. A sequencer that took the interrupt early would break up the call's accesses, and one that let the command win would write R11 before the interrupt entry. Memory back-pressure stays on for every flow, so a sequencer that advanced without a handshake would lose reads or writes.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;

  localparam int SLOT_LINK = 11;
  localparam int SLOT_WP   = 13;
  localparam int SLOT_PC   = 14;
  localparam int SLOT_ST   = 15;

  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_RET  = 2'd1,
    OP_BL   = 2'd2,
    OP_NONE = 2'd3
  } ctx_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VEC_WP,
    S_VEC_PC,
    S_SAVE_WP,
    S_SAVE_PC,
    S_SAVE_ST,
    S_LOAD_WP,
    S_LOAD_PC,
    S_LOAD_ST,
    S_LINK
  } ctx_state_e;

endpackage

// File: rtl/ctx_start_arb.sv
module ctx_start_arb #(
  parameter int LW = 4
) (
  input  logic          idle,
  input  logic          irq_req,
  input  logic [LW-1:0] irq_level,
  input  logic [LW-1:0] irq_mask,
  output logic          take_irq,
  output logic          cmd_ready
);

  logic level_ok;

  always_comb begin
    level_ok  = (irq_level >= irq_mask);
    take_irq  = idle && irq_req && level_ok;
    cmd_ready = idle && !take_irq;
  end

endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
  import ctx_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  ctx_state_e    state,
  input  logic [AW-1:0] vec_base,
  input  logic [AW-1:0] cur_wp,
  input  logic [AW-1:0] new_wp,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] OFS_LINK = AW'(2 * SLOT_LINK);
  localparam logic [AW-1:0] OFS_WP   = AW'(2 * SLOT_WP);
  localparam logic [AW-1:0] OFS_PC   = AW'(2 * SLOT_PC);
  localparam logic [AW-1:0] OFS_ST   = AW'(2 * SLOT_ST);
  localparam logic [AW-1:0] EVEN     = ~AW'(1);

  logic [AW-1:0] raw;

  always_comb begin
    unique case (state)
      S_VEC_WP:  raw = vec_base;
      S_VEC_PC:  raw = vec_base + AW'(2);
      S_SAVE_WP: raw = new_wp + OFS_WP;
      S_SAVE_PC: raw = new_wp + OFS_PC;
      S_SAVE_ST: raw = new_wp + OFS_ST;
      S_LOAD_WP: raw = cur_wp + OFS_WP;
      S_LOAD_PC: raw = cur_wp + OFS_PC;
      S_LOAD_ST: raw = cur_wp + OFS_ST;
      S_LINK:    raw = cur_wp + OFS_LINK;
      default:   raw = cur_wp;
    endcase
    addr = raw & EVEN;
  end

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
  import ctx_seq_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            DW      = 16,
  parameter int            LW      = 4,
  parameter logic [AW-1:0] RST_WP  = 16'h0080,
  parameter logic [AW-1:0] RST_PC  = 16'h0040,
  parameter logic [DW-1:0] RST_ST  = 16'h0005,
  parameter logic [AW-1:0] IRQ_VEC = 16'h0008
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] cmd_next_pc,
  input  logic          irq_req,
  input  logic [LW-1:0] irq_level,
  output logic          irq_ack,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] st,
  output logic          busy
);

  ctx_state_e    state;
  logic          pend;
  logic [AW-1:0] vec_base;
  logic [AW-1:0] save_pc;
  logic [AW-1:0] new_wp;
  logic [AW-1:0] new_pc;
  logic          take_irq;
  logic          idle;
  logic          acc_done;
  logic          rd_done;

  assign idle = (state == S_IDLE);
  assign busy = !idle;

  ctx_start_arb #(.LW(LW)) i_arb (
    .idle      (idle),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .irq_mask  (st[LW-1:0]),
    .take_irq  (take_irq),
    .cmd_ready (cmd_ready)
  );

  assign irq_ack = take_irq;

  ctx_addr_gen #(.AW(AW)) i_addr (
    .state    (state),
    .vec_base (vec_base),
    .cur_wp   (wp),
    .new_wp   (new_wp),
    .addr     (req_addr)
  );

  always_comb begin
    req_valid = busy && !pend;
    req_we    = (state == S_SAVE_WP) || (state == S_SAVE_PC) ||
                (state == S_SAVE_ST) || (state == S_LINK);
    unique case (state)
      S_SAVE_WP: req_wdata = DW'(wp);
      S_SAVE_ST: req_wdata = st;
      S_SAVE_PC,
      S_LINK:    req_wdata = DW'(save_pc);
      default:   req_wdata = '0;
    endcase
    acc_done = req_valid && req_ready;
    rd_done  = pend && rsp_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pend     <= 1'b0;
      vec_base <= '0;
      save_pc  <= '0;
      new_wp   <= '0;
      new_pc   <= '0;
      wp       <= RST_WP;
      pc       <= RST_PC;
      st       <= RST_ST;
    end else begin
      if (acc_done && !req_we) pend <= 1'b1;
      if (rd_done)             pend <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (take_irq) begin
            vec_base <= IRQ_VEC;
            save_pc  <= pc;
            state    <= S_VEC_WP;
          end else if (cmd_valid) begin
            vec_base <= cmd_addr;
            save_pc  <= cmd_next_pc;
            unique case (ctx_op_e'(cmd_op))
              OP_CALL: state <= S_VEC_WP;
              OP_RET:  state <= S_LOAD_WP;
              OP_BL:   state <= S_LINK;
              default: state <= S_IDLE;
            endcase
          end
        end
        S_VEC_WP:  if (rd_done) begin
                     new_wp <= {rsp_data[AW-1:1], 1'b0};
                     state  <= S_VEC_PC;
                   end
        S_VEC_PC:  if (rd_done) begin
                     new_pc <= AW'(rsp_data);
                     state  <= S_SAVE_WP;
                   end
        S_SAVE_WP: if (acc_done) state <= S_SAVE_PC;
        S_SAVE_PC: if (acc_done) state <= S_SAVE_ST;
        S_SAVE_ST: if (acc_done) begin
                     wp    <= new_wp;
                     pc    <= new_pc;
                     state <= S_IDLE;
                   end
        S_LOAD_WP: if (rd_done) begin
                     new_wp <= {rsp_data[AW-1:1], 1'b0};
                     state  <= S_LOAD_PC;
                   end
        S_LOAD_PC: if (rd_done) begin
                     new_pc <= AW'(rsp_data);
                     state  <= S_LOAD_ST;
                   end
        S_LOAD_ST: if (rd_done) begin
                     wp    <= new_wp;
                     pc    <= new_pc;
                     st    <= rsp_data;
                     state <= S_IDLE;
                   end
        S_LINK:    if (acc_done) begin
                     pc    <= vec_base;
                     state <= S_IDLE;
                   end
        default:   state <= S_IDLE;
      endcase
    end
  end

  // R9
  even_addr_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !req_addr[0]);

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_we) && $stable(req_wdata)));

  // R3
  call_vec_first_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd0) |=>
      (req_valid && !req_we && req_addr == {$past(cmd_addr[AW-1:1]), 1'b0}));

  // R6
  irq_vec_first_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (req_valid && !req_we && req_addr == {IRQ_VEC[AW-1:1], 1'b0}));

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!cmd_ready && !irq_ack));

  // R8
  wp_switch_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wp) |-> ($past(busy) && !busy));

endmodule

// File: tb/test_ctx_switch_seq.sv
module test_ctx_switch_seq;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [AW-1:0] cmd_next_pc = '0;
  logic          irq_req = 1'b0;
  logic [LW-1:0] irq_level = '0;
  logic          irq_ack;
  logic          req_valid;
  logic          req_ready;
  logic          req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic [AW-1:0] wp;
  logic [AW-1:0] pc;
  logic [DW-1:0] st;
  logic          busy;

  ctx_switch_seq i_ctx_switch_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_next_pc(cmd_next_pc),
    .irq_req(irq_req), .irq_level(irq_level), .irq_ack(irq_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wp(wp), .pc(pc), .st(st), .busy(busy)
  );

  always #5 clk = ~clk;

  logic [DW-1:0] mem [0:1023];
  logic [2:0]    stall_cnt = '0;
  logic [AW-1:0] log_addr [0:15];
  logic          log_we [0:15];
  int            log_n = 0;
  int            ack_cnt = 0;
  int            ack_logn = 0;
  int            checks = 0;
  int            errors = 0;
  int            cycles = 0;

  assign req_ready = (stall_cnt[1:0] != 2'b01);

  always @(posedge clk) begin
    cycles    <= cycles + 1;
    stall_cnt <= stall_cnt + 3'd1;
    rsp_valid <= 1'b0;
    if (irq_ack) begin
      ack_cnt  <= ack_cnt + 1;
      ack_logn <= log_n;
    end
    if (!rst && req_valid && req_ready) begin
      if (log_n < 16) begin
        log_addr[log_n] <= req_addr;
        log_we[log_n]   <= req_we;
      end
      log_n <= log_n + 1;
      if (req_we) mem[req_addr[10:1]] <= req_wdata;
      else begin
        rsp_data  <= mem[req_addr[10:1]];
        rsp_valid <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mem[a[10:1]] = d;
  endtask

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    return mem[a[10:1]];
  endfunction

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [AW-1:0] npc);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_next_pc = npc; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    check("R1 wp", 32'(wp), 32'h0080);
    check("R1 pc", 32'(pc), 32'h0040);
    check("R1 st", 32'(st), 32'h0005);
    check("R1 busy", 32'(busy), 0);
    check("R1 cmd_ready", 32'(cmd_ready), 1);
  endtask

  task automatic t_call();
    wr(16'h0100, 16'h0200);
    wr(16'h0102, 16'h0400);
    log_n = 0;
    issue(2'd0, 16'h0101, 16'h0302);
    check("R3 access count", 32'(log_n), 5);
    check("R9 vec addr even", 32'(log_addr[0]), 32'h0100);
    check("R3 second read", 32'(log_addr[1]), 32'h0102);
    check("R2 R3 slot13 addr", 32'(log_addr[2]), 32'h021A);
    check("R2 R3 slot14 addr", 32'(log_addr[3]), 32'h021C);
    check("R2 R3 slot15 addr", 32'(log_addr[4]), 32'h021E);
    check("R3 read/write kinds", {log_we[0], log_we[1], log_we[2], log_we[3], log_we[4]}, 5'b00111);
    check("R3 saved wp", 32'(rd(16'h021A)), 32'h0080);
    check("R3 saved pc", 32'(rd(16'h021C)), 32'h0302);
    check("R3 saved st", 32'(rd(16'h021E)), 32'h0005);
    check("R3 new wp", 32'(wp), 32'h0200);
    check("R3 new pc", 32'(pc), 32'h0400);
    check("R3 st kept", 32'(st), 32'h0005);
  endtask

  task automatic t_ret();
    wr(16'h021C, rd(16'h021C) + 16'd2);
    wr(16'h021E, 16'h0015);
    log_n = 0;
    issue(2'd1, 16'h0000, 16'h0000);
    check("R4 access count", 32'(log_n), 3);
    check("R4 read order", {16'(log_addr[0]), 16'(log_addr[2])}, 32'h021A021E);
    check("R4 reads only", {log_we[0], log_we[1], log_we[2]}, 3'b000);
    check("R4 wp", 32'(wp), 32'h0080);
    check("R4 pc after in-line skip", 32'(pc), 32'h0304);
    check("R4 st", 32'(st), 32'h0015);
  endtask

  task automatic t_bl();
    log_n = 0;
    issue(2'd2, 16'h0500, 16'h0306);
    check("R5 access count", 32'(log_n), 1);
    check("R2 R5 slot11 addr", 32'(log_addr[0]), 32'h0096);
    check("R5 is write", 32'(log_we[0]), 1);
    check("R5 link value", 32'(rd(16'h0096)), 32'h0306);
    check("R5 pc", 32'(pc), 32'h0500);
    check("R5 wp kept", 32'(wp), 32'h0080);
    check("R5 st kept", 32'(st), 32'h0015);
  endtask

  task automatic t_irq_masked();
    int a0;
    a0 = ack_cnt;
    log_n = 0;
    @(negedge clk);
    irq_level = 4'd4; irq_req = 1'b1;
    repeat (20) @(negedge clk);
    irq_req = 1'b0;
    check("R7 no ack", 32'(ack_cnt - a0), 0);
    check("R7 no access", 32'(log_n), 0);
    check("R7 pc kept", 32'(pc), 32'h0500);
    check("R7 busy low", 32'(busy), 0);
  endtask

  task automatic t_irq_equal();
    int a0;
    wr(16'h0008, 16'h0300);
    wr(16'h000A, 16'h0600);
    a0 = ack_cnt;
    log_n = 0;
    @(negedge clk);
    irq_level = 4'd5; irq_req = 1'b1;
    while (ack_cnt == a0) @(negedge clk);
    irq_req = 1'b0;
    wait_idle();
    check("R6 one ack", 32'(ack_cnt - a0), 1);
    check("R6 access count", 32'(log_n), 5);
    check("R6 fixed vector", {16'(log_addr[0]), 16'(log_addr[1])}, 32'h0008000A);
    check("R6 saved wp", 32'(rd(16'h031A)), 32'h0080);
    check("R6 saved pc", 32'(rd(16'h031C)), 32'h0500);
    check("R6 saved st", 32'(rd(16'h031E)), 32'h0015);
    check("R6 wp", 32'(wp), 32'h0300);
    check("R6 pc", 32'(pc), 32'h0600);
  endtask

  task automatic t_irq_wait_priority();
    int a0;
    issue(2'd1, 16'h0000, 16'h0000);
    check("R4 back to caller wp", 32'(wp), 32'h0080);
    a0 = ack_cnt;
    log_n = 0;
    @(negedge clk);
    cmd_op = 2'd0; cmd_addr = 16'h0100; cmd_next_pc = 16'h0502; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_op = 2'd2; cmd_addr = 16'h0700; cmd_next_pc = 16'h0A02;
    irq_level = 4'd9; irq_req = 1'b1;
    forever begin
      @(negedge clk); #1;
      if (ack_cnt != a0) irq_req = 1'b0;
      if (cmd_ready) begin
        @(negedge clk);
        cmd_valid = 1'b0;
        break;
      end
    end
    wait_idle();
    check("R8 ack after call done", 32'(ack_logn), 5);
    check("R8 total accesses", 32'(log_n), 11);
    check("R8 irq before cmd", 32'(log_addr[5]), 32'h0008);
    check("R8 cmd last", 32'(log_addr[10]), 32'h0316);
    check("R8 irq saved pc", 32'(rd(16'h031C)), 32'h0400);
    check("R8 irq saved wp", 32'(rd(16'h031A)), 32'h0200);
    check("R11 link in irq ws", 32'(rd(16'h0316)), 32'h0A02);
    check("R8 final pc", 32'(pc), 32'h0700);
    check("R8 final wp", 32'(wp), 32'h0300);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_call();
    t_ret();
    t_bl();
    t_irq_masked();
    t_irq_equal();
    t_irq_wait_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule